// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control Unit

This block decides, every cycle, how a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) keeps correct data flowing between dependent instructions. It reads the register numbers of the instructions in decode and execute, together with the destination numbers, write enables and load flags of the older instructions further down the pipe. From these it produces the select codes for the ALU operand multiplexers, the select bits for the equality comparator that resolves branches in decode, and the pipeline control signals: hold the PC, hold the IF/ID register, zero the ID/EX control bits (bubble) and flush the IF/ID register.

An ALU result waiting in the EX/MEM register is routed straight back to an ALU input. A result in MEM/WB is routed back when no younger result matches. A load followed at once by a consumer costs one stall cycle, and the loaded value is then taken from MEM/WB. Fetch always continues sequentially. When the decode-stage comparator finds a branch taken, the one wrong-path instruction in IF/ID is flushed. The register file writes before it reads within a cycle, so a writeback needs no path back into decode. The block is purely combinational. It sits beside the datapath, the register file and the ALU, which are not part of it.

Top module: `hzd_unit`

## Requirements
- R1: An execute-stage source that equals a valid EX/MEM destination (write enable high, not a load, number not zero) selects code 2'b10 on its operand select. This holds even when MEM/WB also matches.
- R2: An execute-stage source with no valid EX/MEM match that equals a valid MEM/WB destination (write enable high, number not zero) selects code 2'b01. Loads in MEM/WB forward as well.
- R3: Register number zero never produces a forward select, a branch operand select or a stall, whatever the other stages hold.
- R4: A stage whose write enable is low never causes a forward or a stall, even when its destination number matches.
- R5: A load in EX/MEM is never forwarded from EX/MEM. An execute source that matches it takes the MEM/WB path or the register file path (2'b00) instead.
- R6: A load in ID/EX whose destination equals either decode source raises pc_hold, ifid_hold and idex_bubble together in that cycle.
- R7: A decode source equal to a valid non-load EX/MEM destination raises that source's branch operand select bit (1 = take the EX/MEM result).
- R8: A branch in decode stalls when either of its sources equals the destination of a writing non-load instruction in ID/EX, or of a load in EX/MEM.
- R9: With no stall, a branch in decode flushes IF/ID when it is taken: the equal-type when the comparator reports equal, the not-equal type when it reports unequal. Otherwise there is no flush.
- R10: A flush is never raised in a cycle that stalls.
- R11: With no matching stage, all selects read 2'b00 or 0, and no stall or flush is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_i | input | REG_W | First source register of the decode instruction |
| id_rt_i | input | REG_W | Second source register of the decode instruction |
| id_branch_i | input | 1 | Decode instruction is a conditional branch |
| id_branch_ne_i | input | 1 | Branch is taken on inequality (0: taken on equality) |
| br_equal_i | input | 1 | Decode comparator result, 1 when operands are equal |
| ex_rs_i | input | REG_W | First source register of the execute instruction |
| ex_rt_i | input | REG_W | Second source register of the execute instruction |
| idex_rd_i | input | REG_W | Destination register held in ID/EX |
| idex_we_i | input | 1 | ID/EX instruction writes a register |
| idex_load_i | input | 1 | ID/EX instruction is a load |
| exmem_rd_i | input | REG_W | Destination register held in EX/MEM |
| exmem_we_i | input | 1 | EX/MEM instruction writes a register |
| exmem_load_i | input | 1 | EX/MEM instruction is a load |
| memwb_rd_i | input | REG_W | Destination register held in MEM/WB |
| memwb_we_i | input | 1 | MEM/WB instruction writes a register |
| fwd_a_sel_o | output | 2 | ALU operand A source: 00 regfile, 01 MEM/WB, 10 EX/MEM |
| fwd_b_sel_o | output | 2 | ALU operand B source, same codes |
| br_fwd_a_o | output | 1 | Comparator operand A from EX/MEM result |
| br_fwd_b_o | output | 1 | Comparator operand B from EX/MEM result |
| pc_hold_o | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold_o | output | 1 | Keep the IF/ID register unchanged this cycle |
| idex_bubble_o | output | 1 | Clear the control bits entering ID/EX |
| ifid_flush_o | output | 1 | Discard the instruction in IF/ID |

## Verification
The embedded checks hold on every evaluation. Register zero never forwards. A valid EX/MEM match always wins the operand select. A stage that does not write never stalls. A flush never coincides with a stall and only occurs for a branch. What the checks cannot show is that each select code is the right one for a given mix of stage contents. Cases such as a load in EX/MEM falling back to an older MEM/WB result, or a not-equal branch flushing only on inequality, are shown by the bench's directed vectors against its own expected values.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMWB   = 2'b01,
    SRC_EXMEM   = 2'b10
  } src_sel_e;

  // A producer is a valid match for a consumer source register
  function automatic logic reg_hit(input logic [7:0] src,
                                   input logic [7:0] dst,
                                   input logic       we);
    return we && (dst != 8'd0) && (src == dst);
  endfunction

  // Younger producer wins over older producer
  function automatic src_sel_e pick_src(input logic young_hit,
                                        input logic old_hit);
    if (young_hit)    return SRC_EXMEM;
    else if (old_hit) return SRC_MEMWB;
    else              return SRC_REGFILE;
  endfunction

endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] exmem_rd_i,
  input  logic             exmem_we_i,
  input  logic             exmem_load_i,
  input  logic [REG_W-1:0] memwb_rd_i,
  input  logic             memwb_we_i,
  output logic [1:0]       sel_o
);
  localparam int PAD = 8 - REG_W;

  logic young_hit;
  logic old_hit;
  src_sel_e sel;

  always_comb begin
    young_hit = reg_hit({{PAD{1'b0}}, src_i}, {{PAD{1'b0}}, exmem_rd_i},
                        exmem_we_i && !exmem_load_i);
    old_hit   = reg_hit({{PAD{1'b0}}, src_i}, {{PAD{1'b0}}, memwb_rd_i},
                        memwb_we_i);
    sel       = pick_src(young_hit, old_hit);
    sel_o     = sel;
  end

  always_comb begin
    // R3: register zero reads the register file path
    a_r3_zero_never_fwd: assert ((src_i != '0) || (sel_o == 2'b00));
    // R1: a valid EX/MEM match takes priority
    a_r1_young_priority: assert (!(exmem_we_i && !exmem_load_i && exmem_rd_i != '0
                                   && exmem_rd_i == src_i) || (sel_o == 2'b10));
    // R4: no writer, no forward from that stage
    a_r4_no_we_no_fwd: assert ((exmem_we_i || memwb_we_i) || (sel_o == 2'b00));
  end

endmodule

// File: rtl/hzd_stall_det.sv
module hzd_stall_det
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             id_branch_i,
  input  logic [REG_W-1:0] idex_rd_i,
  input  logic             idex_we_i,
  input  logic             idex_load_i,
  input  logic [REG_W-1:0] exmem_rd_i,
  input  logic             exmem_we_i,
  input  logic             exmem_load_i,
  output logic             load_use_o,
  output logic             branch_wait_o,
  output logic             stall_o
);
  localparam int PAD = 8 - REG_W;

  logic idex_hit;
  logic exmem_hit;

  always_comb begin
    idex_hit = reg_hit({{PAD{1'b0}}, id_rs_i}, {{PAD{1'b0}}, idex_rd_i}, idex_we_i)
            || reg_hit({{PAD{1'b0}}, id_rt_i}, {{PAD{1'b0}}, idex_rd_i}, idex_we_i);
    exmem_hit = reg_hit({{PAD{1'b0}}, id_rs_i}, {{PAD{1'b0}}, exmem_rd_i}, exmem_we_i)
             || reg_hit({{PAD{1'b0}}, id_rt_i}, {{PAD{1'b0}}, exmem_rd_i}, exmem_we_i);
    // R6: load directly ahead of a consumer
    load_use_o    = idex_hit && idex_load_i;
    // R8: branch operand not yet available for the decode comparator
    branch_wait_o = id_branch_i && ((idex_hit && !idex_load_i) ||
                                    (exmem_hit && exmem_load_i));
    stall_o       = load_use_o || branch_wait_o;
  end

  always_comb begin
    a_r4_no_writer_no_stall: assert ((idex_we_i || exmem_we_i) || !stall_o);
    a_r3_zero_no_stall: assert (!((id_rs_i == '0) && (id_rt_i == '0)) || !stall_o);
    a_r8_only_branch_waits: assert (id_branch_i || !branch_wait_o);
  end

endmodule

// File: rtl/hzd_branch_ctl.sv
module hzd_branch_ctl
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             id_branch_i,
  input  logic             id_branch_ne_i,
  input  logic             br_equal_i,
  input  logic [REG_W-1:0] exmem_rd_i,
  input  logic             exmem_we_i,
  input  logic             exmem_load_i,
  input  logic             stall_i,
  output logic             br_fwd_a_o,
  output logic             br_fwd_b_o,
  output logic             flush_o
);
  localparam int PAD = 8 - REG_W;

  logic taken;

  always_comb begin
    br_fwd_a_o = reg_hit({{PAD{1'b0}}, id_rs_i}, {{PAD{1'b0}}, exmem_rd_i},
                         exmem_we_i && !exmem_load_i);
    br_fwd_b_o = reg_hit({{PAD{1'b0}}, id_rt_i}, {{PAD{1'b0}}, exmem_rd_i},
                         exmem_we_i && !exmem_load_i);
    taken      = id_branch_i && (br_equal_i ^ id_branch_ne_i);
    flush_o    = taken && !stall_i;
  end

  always_comb begin
    a_r9_flush_needs_branch: assert (id_branch_i || !flush_o);
    a_r7_no_fwd_from_load: assert (!exmem_load_i || (!br_fwd_a_o && !br_fwd_b_o));
  end

endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             id_branch_i,
  input  logic             id_branch_ne_i,
  input  logic             br_equal_i,
  input  logic [REG_W-1:0] ex_rs_i,
  input  logic [REG_W-1:0] ex_rt_i,
  input  logic [REG_W-1:0] idex_rd_i,
  input  logic             idex_we_i,
  input  logic             idex_load_i,
  input  logic [REG_W-1:0] exmem_rd_i,
  input  logic             exmem_we_i,
  input  logic             exmem_load_i,
  input  logic [REG_W-1:0] memwb_rd_i,
  input  logic             memwb_we_i,
  output logic [1:0]       fwd_a_sel_o,
  output logic [1:0]       fwd_b_sel_o,
  output logic             br_fwd_a_o,
  output logic             br_fwd_b_o,
  output logic             pc_hold_o,
  output logic             ifid_hold_o,
  output logic             idex_bubble_o,
  output logic             ifid_flush_o
);
  localparam int N_OPND = 2;

  logic [REG_W-1:0] ex_src [N_OPND];
  logic [1:0]       ex_sel [N_OPND];
  logic             load_use;
  logic             branch_wait;
  logic             stall;
  logic             flush;

  assign ex_src[0] = ex_rs_i;
  assign ex_src[1] = ex_rt_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    hzd_fwd_sel #(.REG_W(REG_W)) u_fwd (
      .src_i        (ex_src[g]),
      .exmem_rd_i   (exmem_rd_i),
      .exmem_we_i   (exmem_we_i),
      .exmem_load_i (exmem_load_i),
      .memwb_rd_i   (memwb_rd_i),
      .memwb_we_i   (memwb_we_i),
      .sel_o        (ex_sel[g])
    );
  end

  hzd_stall_det #(.REG_W(REG_W)) u_stall (
    .id_rs_i       (id_rs_i),
    .id_rt_i       (id_rt_i),
    .id_branch_i   (id_branch_i),
    .idex_rd_i     (idex_rd_i),
    .idex_we_i     (idex_we_i),
    .idex_load_i   (idex_load_i),
    .exmem_rd_i    (exmem_rd_i),
    .exmem_we_i    (exmem_we_i),
    .exmem_load_i  (exmem_load_i),
    .load_use_o    (load_use),
    .branch_wait_o (branch_wait),
    .stall_o       (stall)
  );

  hzd_branch_ctl #(.REG_W(REG_W)) u_branch (
    .id_rs_i        (id_rs_i),
    .id_rt_i        (id_rt_i),
    .id_branch_i    (id_branch_i),
    .id_branch_ne_i (id_branch_ne_i),
    .br_equal_i     (br_equal_i),
    .exmem_rd_i     (exmem_rd_i),
    .exmem_we_i     (exmem_we_i),
    .exmem_load_i   (exmem_load_i),
    .stall_i        (stall),
    .br_fwd_a_o     (br_fwd_a_o),
    .br_fwd_b_o     (br_fwd_b_o),
    .flush_o        (flush)
  );

  assign fwd_a_sel_o   = ex_sel[0];
  assign fwd_b_sel_o   = ex_sel[1];
  assign pc_hold_o     = stall;
  assign ifid_hold_o   = stall;
  assign idex_bubble_o = stall;
  assign ifid_flush_o  = flush;

  always_comb begin
    // R10: flush from branch control never meets a stall from the detector
    a_r10_no_flush_in_stall: assert (!(flush && stall));
    // R6: a load-use hazard always reaches the hold outputs
    a_r6_load_use_holds: assert (!load_use || (pc_hold_o && idex_bubble_o));
    a_r8_branch_wait_holds: assert (!branch_wait || ifid_hold_o);
  end

endmodule

// File: tb/hzd_unit_bench.sv
module hzd_unit_bench;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [REG_W-1:0] id_rs, id_rt, ex_rs, ex_rt, idex_rd, exmem_rd, memwb_rd;
  logic id_br, id_ne, br_eq, idex_we, idex_ld, exmem_we, exmem_ld, memwb_we;
  logic [1:0] fa, fb;
  logic bfa, bfb, pch, ifh, bub, fl;

  hzd_unit #(.REG_W(REG_W)) u_hzd_unit (
    .id_rs_i(id_rs), .id_rt_i(id_rt), .id_branch_i(id_br),
    .id_branch_ne_i(id_ne), .br_equal_i(br_eq),
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt),
    .idex_rd_i(idex_rd), .idex_we_i(idex_we), .idex_load_i(idex_ld),
    .exmem_rd_i(exmem_rd), .exmem_we_i(exmem_we), .exmem_load_i(exmem_ld),
    .memwb_rd_i(memwb_rd), .memwb_we_i(memwb_we),
    .fwd_a_sel_o(fa), .fwd_b_sel_o(fb), .br_fwd_a_o(bfa), .br_fwd_b_o(bfb),
    .pc_hold_o(pch), .ifid_hold_o(ifh), .idex_bubble_o(bub), .ifid_flush_o(fl)
  );

  // expected bundle: {fa, fb, bfa, bfb, pch, ifh, bub, fl}
  logic [9:0] exp_q[$];
  string      tag_q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [1:0] model_sel(logic [REG_W-1:0] s);
    if (s == 0) return 2'b00;
    if (exmem_we && !exmem_ld && exmem_rd == s) return 2'b10;
    if (memwb_we && memwb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [9:0] model();
    logic st, lu, bw, bx, by, f;
    lu = idex_ld && idex_we && idex_rd != 0 && (idex_rd == id_rs || idex_rd == id_rt);
    bw = id_br && ((idex_we && !idex_ld && idex_rd != 0 &&
                    (idex_rd == id_rs || idex_rd == id_rt)) ||
                   (exmem_we && exmem_ld && exmem_rd != 0 &&
                    (exmem_rd == id_rs || exmem_rd == id_rt)));
    st = lu || bw;
    bx = exmem_we && !exmem_ld && id_rs != 0 && exmem_rd == id_rs;
    by = exmem_we && !exmem_ld && id_rt != 0 && exmem_rd == id_rt;
    f  = id_br && !st && (id_ne ? !br_eq : br_eq);
    return {model_sel(ex_rs), model_sel(ex_rt), bx, by, st, st, st, f};
  endfunction

  task automatic clear();
    {id_rs, id_rt, ex_rs, ex_rt, idex_rd, exmem_rd, memwb_rd} = '0;
    {id_br, id_ne, br_eq, idex_we, idex_ld, exmem_we, exmem_ld, memwb_we} = '0;
  endtask

  // driver: inputs already set by caller at negedge; queue the expectation
  task automatic send(string tag);
    exp_q.push_back(model());
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compare at each posedge while expectations are pending
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [9:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {fa, fb, bfa, bfb, pch, ifh, bub, fl};
      n_run++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s actual=%b expected=%b", t, a, e);
      end
    end
  end

  initial begin
    clear();
    @(negedge clk);
    send("R11 idle");

    // R1: EX/MEM and MEM/WB both match, younger wins
    clear(); ex_rs = 5'd3; ex_rt = 5'd4; exmem_rd = 5'd3; exmem_we = 1;
    memwb_rd = 5'd3; memwb_we = 1; send("R1 priority");
    // R2: only MEM/WB matches operand B
    clear(); ex_rs = 5'd7; ex_rt = 5'd9; memwb_rd = 5'd9; memwb_we = 1;
    exmem_rd = 5'd8; exmem_we = 1; send("R2 older fwd");
    // R3: register zero everywhere
    clear(); ex_rs = 0; ex_rt = 0; id_rs = 0; id_rt = 0; exmem_rd = 0; exmem_we = 1;
    memwb_rd = 0; memwb_we = 1; idex_rd = 0; idex_we = 1; idex_ld = 1; id_br = 1;
    br_eq = 1; send("R3 zero");
    // R4: matching numbers but no write enables
    clear(); ex_rs = 5'd5; ex_rt = 5'd5; exmem_rd = 5'd5; memwb_rd = 5'd5;
    id_rs = 5'd5; idex_rd = 5'd5; idex_ld = 1; send("R4 no we");
    // R5: load in EX/MEM falls back to MEM/WB for A, regfile for B
    clear(); ex_rs = 5'd6; ex_rt = 5'd10; exmem_rd = 5'd10; exmem_we = 1; exmem_ld = 1;
    memwb_rd = 5'd6; memwb_we = 1; send("R5 load no young fwd");
    clear(); ex_rs = 5'd6; exmem_rd = 5'd6; exmem_we = 1; exmem_ld = 1;
    memwb_rd = 5'd6; memwb_we = 1; send("R5 load falls to memwb");
    // R6: load-use on rt
    clear(); id_rs = 5'd1; id_rt = 5'd12; idex_rd = 5'd12; idex_we = 1; idex_ld = 1;
    send("R6 load use");
    // R6 negative: ALU op in ID/EX, no branch, no stall
    clear(); id_rs = 5'd12; idex_rd = 5'd12; idex_we = 1; send("R6 alu no stall");
    // R7: branch operands from EX/MEM
    clear(); id_br = 1; id_rs = 5'd14; id_rt = 5'd15; exmem_rd = 5'd15; exmem_we = 1;
    send("R7 br fwd b");
    // R8: branch waits on ALU op in ID/EX
    clear(); id_br = 1; id_rs = 5'd20; idex_rd = 5'd20; idex_we = 1; br_eq = 1;
    send("R8 R10 branch on alu");
    // R8: branch waits on load in EX/MEM
    clear(); id_br = 1; id_rt = 5'd21; exmem_rd = 5'd21; exmem_we = 1; exmem_ld = 1;
    send("R8 branch on load");
    // R9: equal-type taken / not taken, not-equal type taken / not taken
    clear(); id_br = 1; id_rs = 5'd2; id_rt = 5'd3; br_eq = 1; send("R9 beq taken");
    clear(); id_br = 1; id_rs = 5'd2; id_rt = 5'd3; br_eq = 0; send("R9 beq not taken");
    clear(); id_br = 1; id_ne = 1; br_eq = 0; send("R9 bne taken");
    clear(); id_br = 1; id_ne = 1; br_eq = 1; send("R9 bne not taken");
    // R10: taken branch during load-use stall
    clear(); id_br = 1; br_eq = 1; id_rs = 5'd30; idex_rd = 5'd30; idex_we = 1;
    idex_ld = 1; send("R10 no flush in stall");
    // R11: equal comparator result without a branch
    clear(); br_eq = 1; ex_rs = 5'd1; ex_rt = 5'd2; send("R11 no branch");
    // R1: both operands from EX/MEM with a combined case
    clear(); ex_rs = 5'd31; ex_rt = 5'd31; exmem_rd = 5'd31; exmem_we = 1;
    send("R1 both opnds");
    @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule